// File: doc/BRIEF.md
# Sliding-Window Decoder Run Sequencer

This block is the run-control sequencer for a trellis decoder that works through a frame one window at a time. Each window has two phases. In the metric phase the decoder computes the state metrics for the window. In the traceback phase it produces the decisions for that window. A 4-bit command write starts the decoder, soft-resets it, or drives it through a debug pause. From the pause the decoder can step one window or run on to the end of the frame. The datapath answers with single-cycle pulses: window metrics done, traceback done, and frame done. Frame done is given together with the last traceback done of the frame.

The sequencer drives the metric and traceback enables and a one-cycle start strobe to the datapath. It also drives a soft-reset strobe and four status bits: run, pause, waiting-for-configuration and emulation-halt. Two FIFO levels throttle it:
- An empty input FIFO stalls the metric phase.
- A full output FIFO stalls the traceback phase.

An emulation suspend input halts the decoder. A free-run bit and a soft bit choose where the halt happens. A saturating counter tracks the number of trellis stages processed.

The block has no data stream and so carries no valid/ready handshake. The datapath pulses and all status pins are plain levels or strobes.

Top module: `trellis_run_seq`

## Requirements
- R1: After reset, all enables, strobes and status bits are 0, the stage count is 0, and the block is idle.
- R2: Command 1, written while idle, gives start_pulse high for exactly the next cycle. From that cycle on the metric phase runs (metric_en=1, sts_run=1), and sts_wait_cfg is cleared.
- R3: Command 2, written during the metric or traceback phase, makes the block pause at the next window-metrics-done. The pause holds with sts_pause=1, sts_run=0 and both enables 0, and traceback does not begin.
- R4: Command 3, written while paused, runs that window's traceback and then the next metric window, and pauses again when that window's metrics are done.
- R5: Command 4, written while paused, runs the traceback and then continues window after window without pausing, until the frame ends.
- R6: A traceback-done that comes together with frame-done returns the block to idle (sts_run=0) and sets sts_wait_cfg=1. A traceback-done alone starts the next metric window.
- R7: Command 5 is accepted in every state. It gives soft_rst high for one cycle and returns the block to idle with the stage count, sts_wait_cfg and any pending pause cleared.
- R8: Codes 0 and 6 to 15 have no effect. A command that is not valid in the current state also has no effect: start when not idle, pause when not in a phase, step or resume when not paused.
- R9: In the metric phase with in_level=0, and in the traceback phase with out_level equal to FIFO_DEPTH, the phase enable is 0, sts_pause=1 and sts_run=0. The phase resumes when the level recovers.
- R10: sts_run and sts_pause are never 1 together.
- R11: With emu_free=1, emu_suspend has no effect on sequencing.
- R12: With emu_free=0 and emu_soft=0, a suspend that is high at window-metrics-done halts the block before traceback (sts_emu_halt=1, enables 0). When the suspend falls, traceback starts.
- R13: With emu_free=0 and emu_soft=1, a suspend halts the block only at the end of the frame. The halt holds sts_emu_halt=1 and sts_wait_cfg=1 until the suspend falls, and the block then goes idle.
- R14: stage_cnt counts stage_tick pulses that arrive while metric_en=1. It saturates at frame_len+tail_len when conv_mode=0, and at frame_len+conv_len when conv_mode=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 4 | Command code (1 start, 2 pause, 3 step, 4 resume, 5 soft reset) |
| emu_suspend | input | 1 | Emulation suspend request |
| emu_free | input | 1 | 1: suspend ignored |
| emu_soft | input | 1 | 0: halt at window end; 1: halt at frame end |
| win_done | input | 1 | Window metrics done pulse |
| tb_done | input | 1 | Traceback done pulse |
| frame_done | input | 1 | Last window of frame, qualified with tb_done |
| stage_tick | input | 1 | One trellis stage processed |
| in_level | input | LVL_W | Input FIFO fill level |
| out_level | input | LVL_W | Output FIFO fill level |
| frame_len | input | STAGE_W | Frame length F |
| tail_len | input | EXTRA_W | Tail stages k-1 |
| conv_len | input | EXTRA_W | Convergence stages C |
| conv_mode | input | 1 | 1: convergent traceback |
| start_pulse | output | 1 | One-cycle start strobe |
| metric_en | output | 1 | Metric phase enable |
| trace_en | output | 1 | Traceback phase enable |
| soft_rst | output | 1 | One-cycle soft-reset strobe |
| sts_run | output | 1 | Running status |
| sts_pause | output | 1 | Paused or FIFO-stalled status |
| sts_wait_cfg | output | 1 | Waiting for configuration |
| sts_emu_halt | output | 1 | Halted by emulation |
| stage_cnt | output | STAGE_W | Stages processed |

## Verification
Every registered result is due one clock edge after its stimulus. This covers state moves from commands or datapath pulses, start_pulse, soft_rst and stage_cnt updates. The FIFO stall indications depend only on the current state and the levels, so they follow a level change without a clock edge. The bench drives inputs just after a rising edge and checks registered outputs one edge later, 1 ns after that edge. It checks stall outputs 1 ns after the level change, which keeps every sample clear of the active edge. The command sweep enters each of the four main states, writes all sixteen codes, and compares the observed state signature and strobes with a table computed in the bench.

// File: rtl/run_seq_pkg.sv
package run_seq_pkg;
  localparam logic [3:0] CMD_START  = 4'd1;
  localparam logic [3:0] CMD_HOLD   = 4'd2;
  localparam logic [3:0] CMD_STEP   = 4'd3;
  localparam logic [3:0] CMD_RESUME = 4'd4;
  localparam logic [3:0] CMD_SRST   = 4'd5;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_METRIC = 3'd1,
    ST_TRACE  = 3'd2,
    ST_PAUSED = 3'd3,
    ST_EHALT  = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic go;
    logic hold;
    logic step;
    logic resume;
    logic srst;
  } seq_act_t;
endpackage

// File: rtl/run_cmd_decode.sv
module run_cmd_decode
  import run_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_code,
  input  seq_state_t state,
  output seq_act_t   act
);
  logic in_phase;
  assign in_phase = (state == ST_METRIC) || (state == ST_TRACE);

  always_comb begin
    act = '0;
    if (cmd_wr) begin
      unique case (cmd_code)
        CMD_START:  act.go     = (state == ST_IDLE);
        CMD_HOLD:   act.hold   = in_phase;
        CMD_STEP:   act.step   = (state == ST_PAUSED);
        CMD_RESUME: act.resume = (state == ST_PAUSED);
        CMD_SRST:   act.srst   = 1'b1;
        default:    act = '0;
      endcase
    end
  end

  // R8
  act_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |-> (act == '0));
endmodule

// File: rtl/run_stage_count.sv
module run_stage_count #(
  parameter int STAGE_W = 17,
  parameter int EXTRA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               tick,
  input  logic [STAGE_W-1:0] frame_len,
  input  logic [EXTRA_W-1:0] tail_len,
  input  logic [EXTRA_W-1:0] conv_len,
  input  logic               conv_mode,
  output logic [STAGE_W-1:0] cnt
);
  localparam int SUM_W = STAGE_W + 1;

  logic [SUM_W-1:0] limit;
  logic [EXTRA_W-1:0] extra;
  logic below;

  assign extra = conv_mode ? conv_len : tail_len;
  assign limit = {1'b0, frame_len} + SUM_W'(extra);
  assign below = ({1'b0, cnt} < limit) && (cnt != {STAGE_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear)          cnt <= '0;
    else if (tick && below)  cnt <= cnt + 1'b1;
  end

  // R14
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));
endmodule

// File: rtl/run_fsm.sv
module run_fsm
  import run_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_act_t         act,
  input  logic             emu_suspend,
  input  logic             emu_free,
  input  logic             emu_soft,
  input  logic             win_done,
  input  logic             tb_done,
  input  logic             frame_done,
  input  logic [LVL_W-1:0] in_level,
  input  logic [LVL_W-1:0] out_level,
  output seq_state_t       state,
  output logic             start_pulse,
  output logic             metric_en,
  output logic             trace_en,
  output logic             soft_rst,
  output logic             sts_run,
  output logic             sts_pause,
  output logic             sts_wait_cfg,
  output logic             sts_emu_halt
);
  seq_state_t ret_state;
  logic hold_q;
  logic in_empty, out_full, stall, emu_win, emu_frame;

  assign in_empty  = (in_level == '0);
  assign out_full  = (out_level == LVL_W'(FIFO_DEPTH));
  assign emu_win   = emu_suspend && !emu_free && !emu_soft;
  assign emu_frame = emu_suspend && !emu_free && emu_soft;
  assign stall     = ((state == ST_METRIC) && in_empty) ||
                     ((state == ST_TRACE) && out_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ret_state    <= ST_IDLE;
      hold_q       <= 1'b0;
      sts_wait_cfg <= 1'b0;
      start_pulse  <= 1'b0;
      soft_rst     <= 1'b0;
    end else begin
      start_pulse <= act.go;
      soft_rst    <= act.srst;
      if (act.srst) begin
        state        <= ST_IDLE;
        ret_state    <= ST_IDLE;
        hold_q       <= 1'b0;
        sts_wait_cfg <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: if (act.go) begin
            state        <= ST_METRIC;
            sts_wait_cfg <= 1'b0;
          end
          ST_METRIC: begin
            if (act.hold) hold_q <= 1'b1;
            if (win_done) begin
              if (hold_q || act.hold) begin
                state  <= ST_PAUSED;
                hold_q <= 1'b0;
              end else if (emu_win) begin
                state     <= ST_EHALT;
                ret_state <= ST_TRACE;
              end else begin
                state <= ST_TRACE;
              end
            end
          end
          ST_TRACE: begin
            if (act.hold) hold_q <= 1'b1;
            if (tb_done) begin
              if (frame_done) begin
                sts_wait_cfg <= 1'b1;
                hold_q       <= 1'b0;
                if (emu_frame) begin
                  state     <= ST_EHALT;
                  ret_state <= ST_IDLE;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state <= ST_METRIC;
              end
            end
          end
          ST_PAUSED: begin
            if (act.step) begin
              state  <= ST_TRACE;
              hold_q <= 1'b1;
            end else if (act.resume) begin
              state  <= ST_TRACE;
              hold_q <= 1'b0;
            end
          end
          ST_EHALT: if (!emu_suspend || emu_free) state <= ret_state;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign metric_en    = (state == ST_METRIC) && !in_empty;
  assign trace_en     = (state == ST_TRACE) && !out_full;
  assign sts_pause    = (state == ST_PAUSED) || stall;
  assign sts_run      = ((state == ST_METRIC) || (state == ST_TRACE)) && !stall;
  assign sts_emu_halt = (state == ST_EHALT);

  // R10
  run_pause_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_run && sts_pause));

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(act.go));

  // R6
  wait_cfg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_wait_cfg) |-> $past(tb_done && frame_done));

  // R12
  emu_halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_emu_halt |-> (!metric_en && !trace_en && !sts_run));

  // R3
  pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSED && $past(state) == ST_METRIC) |-> $past(win_done));
endmodule

// File: rtl/trellis_run_seq.sv
module trellis_run_seq
  import run_seq_pkg::*;
#(
  parameter int STAGE_W    = 17,
  parameter int EXTRA_W    = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [3:0]         cmd_code,
  input  logic               emu_suspend,
  input  logic               emu_free,
  input  logic               emu_soft,
  input  logic               win_done,
  input  logic               tb_done,
  input  logic               frame_done,
  input  logic               stage_tick,
  input  logic [LVL_W-1:0]   in_level,
  input  logic [LVL_W-1:0]   out_level,
  input  logic [STAGE_W-1:0] frame_len,
  input  logic [EXTRA_W-1:0] tail_len,
  input  logic [EXTRA_W-1:0] conv_len,
  input  logic               conv_mode,
  output logic               start_pulse,
  output logic               metric_en,
  output logic               trace_en,
  output logic               soft_rst,
  output logic               sts_run,
  output logic               sts_pause,
  output logic               sts_wait_cfg,
  output logic               sts_emu_halt,
  output logic [STAGE_W-1:0] stage_cnt
);
  seq_state_t state;
  seq_act_t   act;

  run_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .state(state), .act(act)
  );

  run_fsm #(.FIFO_DEPTH(FIFO_DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .act(act),
    .emu_suspend(emu_suspend), .emu_free(emu_free), .emu_soft(emu_soft),
    .win_done(win_done), .tb_done(tb_done), .frame_done(frame_done),
    .in_level(in_level), .out_level(out_level), .state(state),
    .start_pulse(start_pulse), .metric_en(metric_en), .trace_en(trace_en),
    .soft_rst(soft_rst), .sts_run(sts_run), .sts_pause(sts_pause),
    .sts_wait_cfg(sts_wait_cfg), .sts_emu_halt(sts_emu_halt)
  );

  run_stage_count #(.STAGE_W(STAGE_W), .EXTRA_W(EXTRA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(act.go || act.srst),
    .tick(stage_tick && metric_en), .frame_len(frame_len),
    .tail_len(tail_len), .conv_len(conv_len), .conv_mode(conv_mode),
    .cnt(stage_cnt)
  );

  // R7
  srst_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (stage_cnt == '0 && !sts_wait_cfg));
endmodule

// File: tb/tb_trellis_run_seq.sv
module tb_trellis_run_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STAGE_W = 17;
  localparam int EXTRA_W = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0; logic [3:0] cmd_code = 0;
  logic emu_suspend = 0, emu_free = 0, emu_soft = 0;
  logic win_done = 0, tb_done = 0, frame_done = 0, stage_tick = 0;
  logic [LVL_W-1:0] in_level = 4, out_level = 0;
  logic [STAGE_W-1:0] frame_len = 5;
  logic [EXTRA_W-1:0] tail_len = 2, conv_len = 3;
  logic conv_mode = 0;
  logic start_pulse, metric_en, trace_en, soft_rst;
  logic sts_run, sts_pause, sts_wait_cfg, sts_emu_halt;
  logic [STAGE_W-1:0] stage_cnt;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trellis_run_seq #(.STAGE_W(STAGE_W), .EXTRA_W(EXTRA_W), .FIFO_DEPTH(FIFO_DEPTH)) dut (
    .clk, .rst_n, .cmd_wr, .cmd_code, .emu_suspend, .emu_free, .emu_soft,
    .win_done, .tb_done, .frame_done, .stage_tick, .in_level, .out_level,
    .frame_len, .tail_len, .conv_len, .conv_mode, .start_pulse, .metric_en,
    .trace_en, .soft_rst, .sts_run, .sts_pause, .sts_wait_cfg, .sts_emu_halt,
    .stage_cnt
  );

  // signature {metric_en, trace_en, run, pause, wait_cfg, emu_halt}
  localparam logic [5:0] SIG_IDLE   = 6'b000000;
  localparam logic [5:0] SIG_METRIC = 6'b101000;
  localparam logic [5:0] SIG_TRACE  = 6'b011000;
  localparam logic [5:0] SIG_PAUSED = 6'b000100;

  function automatic logic [5:0] sig();
    return {metric_en, trace_en, sts_run, sts_pause, sts_wait_cfg, sts_emu_halt};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cmd_wr = 0; win_done = 0; tb_done = 0; frame_done = 0; stage_tick = 0;
  endtask

  task automatic cmd(input logic [3:0] c);
    cmd_wr = 1; cmd_code = c; step();
  endtask

  // state index: 0 idle, 1 metric, 2 trace, 3 paused
  task automatic go_state(input int s);
    cmd(4'd5); step();
    if (s >= 1) cmd(4'd1);
    if (s == 2) begin win_done = 1; step(); end
    if (s == 3) begin cmd(4'd2); win_done = 1; step(); end
  endtask

  function automatic logic [5:0] sig_of(input int s);
    case (s)
      0: return SIG_IDLE;
      1: return SIG_METRIC;
      2: return SIG_TRACE;
      default: return SIG_PAUSED;
    endcase
  endfunction

  function automatic int next_of(input int s, input int c);
    if (c == 5) return 0;
    if (s == 0 && c == 1) return 1;
    if (s == 3 && (c == 3 || c == 4)) return 2;
    return s;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    chk("R1 sig", 32'(sig()), 32'(SIG_IDLE));
    chk("R1 strobes", {start_pulse, soft_rst}, 0);
    chk("R1 count", stage_cnt, 0);
    rst_n = 1; step();

    // R8 sweep of all codes in all main states (also R2, R7 strobes)
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 16; c++) begin
        go_state(s);
        chk("R8 pre-state", 32'(sig()), 32'(sig_of(s)));
        cmd(4'(c));
        chk("R8 state after code", 32'(sig()), 32'(sig_of(next_of(s, c))));
        chk("R2 start strobe", start_pulse, (s == 0 && c == 1));
        chk("R7 soft_rst strobe", soft_rst, (c == 5));
      end
    end

    // R2 start, one-cycle pulse
    go_state(0);
    cmd(4'd1);
    chk("R2 start pulse", start_pulse, 1);
    chk("R2 running", 32'(sig()), 32'(SIG_METRIC));
    step();
    chk("R2 pulse single cycle", start_pulse, 0);

    // R14 counting and saturation in tailed mode (limit 5+2=7)
    for (int i = 0; i < 3; i++) begin stage_tick = 1; step(); end
    chk("R14 count 3", stage_cnt, 3);
    for (int i = 0; i < 8; i++) begin stage_tick = 1; step(); end
    chk("R14 tailed saturate", stage_cnt, 7);
    // R14 convergent mode (limit 5+3=8)
    conv_mode = 1;
    for (int i = 0; i < 4; i++) begin stage_tick = 1; step(); end
    chk("R14 conv saturate", stage_cnt, 8);
    conv_mode = 0;
    // R14 ticks while stalled are not counted; R9 input stall
    cmd(4'd5);
    cmd(4'd1);
    in_level = 0; #1;
    chk("R9 metric stall sig", 32'(sig()), 32'(6'b000100));
    stage_tick = 1; step();
    chk("R14 no count when stalled", stage_cnt, 0);
    in_level = 4; #1;
    chk("R9 metric recover", 32'(sig()), 32'(SIG_METRIC));
    // R7 soft reset clears count
    stage_tick = 1; step();
    chk("R14 count 1", stage_cnt, 1);
    cmd(4'd5);
    chk("R7 count cleared", stage_cnt, 0);
    chk("R7 idle", 32'(sig()), 32'(SIG_IDLE));

    // R9 output stall in traceback
    go_state(2);
    out_level = LVL_W'(FIFO_DEPTH); #1;
    chk("R9 trace stall sig", 32'(sig()), 32'(6'b000100));
    out_level = 0; #1;
    chk("R9 trace recover", 32'(sig()), 32'(SIG_TRACE));

    // R3 pause holds; R4 step one window
    go_state(1);
    cmd(4'd2);
    chk("R3 no pause before window end", 32'(sig()), 32'(SIG_METRIC));
    win_done = 1; step();
    chk("R3 paused", 32'(sig()), 32'(SIG_PAUSED));
    tb_done = 1; step(); step();
    chk("R3 pause holds", 32'(sig()), 32'(SIG_PAUSED));
    cmd(4'd3);
    chk("R4 step traceback", 32'(sig()), 32'(SIG_TRACE));
    tb_done = 1; step();
    chk("R4 next metric", 32'(sig()), 32'(SIG_METRIC));
    win_done = 1; step();
    chk("R4 paused again", 32'(sig()), 32'(SIG_PAUSED));

    // R5 resume to completion; R6 frame end
    cmd(4'd4);
    chk("R5 traceback", 32'(sig()), 32'(SIG_TRACE));
    tb_done = 1; step();
    chk("R6 next window", 32'(sig()), 32'(SIG_METRIC));
    win_done = 1; step();
    chk("R5 no pause", 32'(sig()), 32'(SIG_TRACE));
    tb_done = 1; frame_done = 1; step();
    chk("R6 frame end", 32'(sig()), 32'(6'b000010));
    cmd(4'd1);
    chk("R2 wait_cfg cleared", 32'(sig()), 32'(SIG_METRIC));

    // R11 free run ignores suspend
    go_state(1);
    emu_free = 1; emu_suspend = 1;
    win_done = 1; step();
    chk("R11 no halt at window", 32'(sig()), 32'(SIG_TRACE));
    tb_done = 1; frame_done = 1; step();
    chk("R11 no halt at frame", 32'(sig()), 32'(6'b000010));
    emu_free = 0; emu_suspend = 0;

    // R12 window-boundary halt
    go_state(1);
    emu_suspend = 1; win_done = 1; step();
    chk("R12 halted", 32'(sig()), 32'(6'b000001));
    step();
    chk("R12 halt holds", 32'(sig()), 32'(6'b000001));
    emu_suspend = 0; step();
    chk("R12 traceback after release", 32'(sig()), 32'(SIG_TRACE));

    // R13 frame-boundary halt
    go_state(1);
    emu_soft = 1; emu_suspend = 1;
    win_done = 1; step();
    chk("R13 no halt at window", 32'(sig()), 32'(SIG_TRACE));
    tb_done = 1; step();
    chk("R13 next window", 32'(sig()), 32'(SIG_METRIC));
    win_done = 1; step();
    tb_done = 1; frame_done = 1; step();
    chk("R13 halted at frame end", 32'(sig()), 32'(6'b000011));
    emu_suspend = 0; step();
    chk("R13 idle after release", 32'(sig()), 32'(6'b000010));
    emu_soft = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule